// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of interrupt lines from peripherals and presents a single request line to a processor. Each line can be captured on a rising edge or sampled as a level. Each line has its own mask bit and a small programmable priority, where a larger number is more urgent and zero turns the line off. Captured requests sit in a pending register. The controller continually picks the most urgent unmasked pending request that outranks everything currently being serviced, and raises `irq_o` while such a request exists.

Software reads an acknowledge register to take the winner. The read returns the winning line number, moves that line from pending to in-service, and records it as the current interrupt. If nothing is eligible, the read returns a spurious code. When the handler finishes, software writes the line number to the end-of-interrupt register, which clears that in-service bit. Nesting follows from the in-service register: only a strictly more urgent request can raise `irq_o` while a handler runs.

The winner and the pending-view register are both registered copies. As a result, an acknowledge read issued in the cycle straight after a configuration write still sees the arbitration from before the write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, the mask register reads all ones (every line masked), the trigger register reads zero (all level mode), every priority is 0, and the pending and in-service registers read zero.
- R2: A line whose trigger bit (register 1) is 1 sets its pending bit on a rising edge. A line held high does not set the bit again after the bit has been cleared.
- R3: A line whose trigger bit is 0 sets its pending bit in every cycle it is high. An acknowledge or a write-one-to-clear of pending (register 5) therefore leaves the bit set while the line stays high.
- R4: A pending bit is latched even when its mask bit (register 0, 1 = masked) is set or its priority is 0. Neither a masked line nor a line with priority 0 can raise `irq_o` or win an acknowledge.
- R5: Priorities are written to register 2, with the line number in bits [3:0] and the priority in bits [11:8]. Among eligible requests, the one with the highest priority wins. On equal priority, the lower line number wins. An acknowledge read (register 3) returns the winner number in bits [4:0].
- R6: An accepted acknowledge sets the winner's bit in the in-service register (register 6) and clears its pending bit.
- R7: `irq_o` is high only while an unmasked pending request has a priority strictly above the highest priority in service. A request of equal priority waits until the EOI, and a higher one preempts.
- R8: A write of a line number to register 4 (EOI) clears that in-service bit. An EOI for a line that is not in service changes nothing.
- R9: An acknowledge read when no request is eligible returns 5'b11111 and changes no state.
- R10: The acknowledge winner and the pending view (register 5 read) lag the internal state by one cycle. A mask write immediately followed by an acknowledge read returns the winner from before the write.
- R11: Register 7 reads {bit 8 = valid, bits [3:0] = line}. An accepted acknowledge sets it to the taken line with valid high, and an effective EOI clears valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Interrupt lines, bit i is line i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledge read has side effects) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of `reg_rd` |
| irq_o | output | 1 | Request to the processor |

## Verification
Sixteen line pairs are swept. Their priorities are computed from the pair index, so the set includes strict wins in both directions and exact ties. This separates priority ordering from the tie-break by line number, and each pair also checks that the loser is held off until the winner's EOI.

Directed sequences cover the remaining behaviour:
- Preemption by a higher priority, and blocking by an equal one.
- Masked lines and lines with priority 0 that still latch as pending.
- A held edge line, which must not re-post.
- A held level line, which must re-post through both acknowledge and clear.
- Back-to-back accesses that expose the one-cycle view latency.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

    // Register selects
    typedef enum logic [2:0] {
        SEL_MASK = 3'd0,
        SEL_TRIG = 3'd1,
        SEL_PRIO = 3'd2,
        SEL_ACK  = 3'd3,
        SEL_EOI  = 3'd4,
        SEL_PEND = 3'd5,
        SEL_ISR  = 3'd6,
        SEL_CUR  = 3'd7
    } reg_sel_e;

    // Bit position of the priority value within a priority write
    localparam int PRIO_FIELD_LSB = 8;
    // Valid flag position in the current-interrupt view
    localparam int CUR_VALID_BIT  = 8;

    function automatic logic [63:0] onehot64(input int unsigned idx);
        logic [63:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/prio_irq_capture.sv
`timescale 1ns/1ps
module prio_irq_capture #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic [N_SRC-1:0] edge_mode,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        logic hit;
        // Edge lines fire once per rising edge, level lines every high cycle
        assign hit = edge_mode[i] ? (irq_in[i] & ~prev_q[i]) : irq_in[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= irq_in[i];
                // A new hit outranks a clear in the same cycle
                pend_q[i] <= (pend_q[i] & ~clr[i]) | hit;
            end
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/prio_irq_arbiter.sv
`timescale 1ns/1ps
module prio_irq_arbiter #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 4,
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]        pend,
    input  logic [N_SRC-1:0]        mask,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    input  logic [N_SRC-1:0]        isr,
    output logic                    win_valid,
    output logic [ID_W-1:0]         win_id,
    output logic [PRIO_W-1:0]       isr_top
);
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] top_p;

    // Highest priority currently in service
    always_comb begin
        top_p = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (isr[i] && prio_flat[i*PRIO_W +: PRIO_W] > top_p)
                top_p = prio_flat[i*PRIO_W +: PRIO_W];
        end
    end

    // Ascending scan with strict compare: lower index keeps a tie
    always_comb begin
        best_p  = '0;
        best_id = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && !mask[i] &&
                prio_flat[i*PRIO_W +: PRIO_W] > top_p &&
                prio_flat[i*PRIO_W +: PRIO_W] > best_p) begin
                best_p  = prio_flat[i*PRIO_W +: PRIO_W];
                best_id = ID_W'(i);
            end
        end
    end

    assign win_valid = (best_p != '0);
    assign win_id    = best_id;
    assign isr_top   = top_p;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int ACK_W = ID_W + 1;
    localparam logic [ACK_W-1:0] SPURIOUS = '1;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } irq_ref_t;

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    logic [N_SRC-1:0]        mask_q;
    logic [N_SRC-1:0]        trig_q;
    logic [PRIO_W-1:0]       prio_q [N_SRC];
    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic [N_SRC-1:0]        isr_q;
    logic [N_SRC-1:0]        pend_q;
    logic [N_SRC-1:0]        pend_view_q;
    logic [N_SRC-1:0]        pend_clr;
    irq_ref_t                win_c, win_q, cur_q;
    logic [PRIO_W-1:0]       isr_top;

    logic            ack_rd, ack_take, eoi_wr, eoi_hit;
    logic [ID_W-1:0] ack_id, eoi_id, wr_idx;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_idx = reg_wdata[ID_W-1:0];

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            trig_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK) mask_q <= reg_wdata[N_SRC-1:0];
            if (sel == SEL_TRIG) trig_q <= reg_wdata[N_SRC-1:0];
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[i] <= '0;
            else if (reg_wr && sel == SEL_PRIO && wr_idx == ID_W'(i))
                prio_q[i] <= reg_wdata[PRIO_FIELD_LSB +: PRIO_W];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // Acknowledge and end-of-interrupt decode
    assign ack_rd   = reg_rd && (sel == SEL_ACK);
    assign ack_id   = win_q.id;
    assign ack_take = ack_rd && win_q.valid && pend_q[win_q.id];
    assign eoi_wr   = reg_wr && (sel == SEL_EOI);
    assign eoi_id   = reg_wdata[ID_W-1:0];
    assign eoi_hit  = eoi_wr && isr_q[eoi_id];

    always_comb begin
        pend_clr = '0;
        if (reg_wr && sel == SEL_PEND)
            pend_clr = reg_wdata[N_SRC-1:0];
        if (ack_take)
            pend_clr = pend_clr | N_SRC'(onehot64(32'(ack_id)));
    end

    prio_irq_capture #(.N_SRC(N_SRC)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .edge_mode (trig_q),
        .clr       (pend_clr),
        .pend      (pend_q)
    );

    prio_irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) arb_i (
        .pend      (pend_q),
        .mask      (mask_q),
        .prio_flat (prio_flat),
        .isr       (isr_q),
        .win_valid (win_c.valid),
        .win_id    (win_c.id),
        .isr_top   (isr_top)
    );

    // In-service register, current-interrupt record and registered views
    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q       <= '0;
            cur_q       <= '0;
            win_q       <= '0;
            pend_view_q <= '0;
        end else begin
            win_q       <= win_c;
            pend_view_q <= pend_q;
            if (eoi_hit)
                isr_q[eoi_id] <= 1'b0;
            if (ack_take)
                isr_q[ack_id] <= 1'b1;
            if (ack_take)
                cur_q <= '{valid: 1'b1, id: ack_id};
            else if (eoi_hit)
                cur_q.valid <= 1'b0;
        end
    end

    assign irq_o = win_q.valid;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (sel)
                SEL_MASK: reg_rdata[N_SRC-1:0] = mask_q;
                SEL_TRIG: reg_rdata[N_SRC-1:0] = trig_q;
                SEL_ACK:  reg_rdata[ACK_W-1:0] = ack_take ? {1'b0, ack_id} : SPURIOUS;
                SEL_PEND: reg_rdata[N_SRC-1:0] = pend_view_q;
                SEL_ISR:  reg_rdata[N_SRC-1:0] = isr_q;
                SEL_CUR: begin
                    reg_rdata[ID_W-1:0]      = cur_q.id;
                    reg_rdata[CUR_VALID_BIT] = cur_q.valid;
                end
                default:  reg_rdata = '0;
            endcase
        end
    end

    logic unused_top;
    assign unused_top = ^isr_top;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int ACK_W = ID_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_SRC-1:0]  isr_q,
    input logic [N_SRC-1:0]  pend_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic              ack_take,
    input logic [ID_W-1:0]   ack_id
);
    // R6: a taken acknowledge puts the line in service
    a_r6_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> isr_q[$past(ack_id)]);

    // R9: a refused acknowledge reads the spurious code
    a_r9_spurious_code: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd3 && !ack_take) |-> (reg_rdata[ACK_W-1:0] == '1));

    // R9: a refused acknowledge leaves the in-service set alone
    a_r9_spurious_quiet: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd3 && !ack_take && !reg_wr) |=> isr_q == $past(isr_q));

    // R8: EOI clears its line unless that line is taken again in the same cycle
    a_r8_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd4 && !(ack_take && ack_id == reg_wdata[ID_W-1:0]))
        |=> !isr_q[$past(reg_wdata[ID_W-1:0])]);

    // R8: EOI for a line not in service changes nothing
    a_r8_eoi_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd4 && !isr_q[reg_wdata[ID_W-1:0]] && !ack_take)
        |=> isr_q == $past(isr_q));

    // R4: the request line needs some unmasked pending request one cycle before
    a_r4_irq_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(pend_q & ~mask_q)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam logic [2:0] A_MASK = 3'd0, A_TRIG = 3'd1, A_PRIO = 3'd2, A_ACK = 3'd3,
                           A_EOI = 3'd4, A_PEND = 3'd5, A_ISR = 3'd6, A_CUR = 3'd7;
    localparam logic [31:0] SPUR = 32'd31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N), .PRIO_W(4), .DATA_W(32)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_prio(input int line, input int p);
        wr(A_PRIO, 32'((p << 8) | line));
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        @(negedge clk);
        irq_in = irq_in | bits;
        @(negedge clk);
        irq_in = irq_in & ~bits;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        rd(A_MASK, d); chk("R1 mask", d, 32'h0000_FFFF);
        rd(A_TRIG, d); chk("R1 trig", d, 32'd0);
        rd(A_PEND, d); chk("R1 pend", d, 32'd0);
        rd(A_ISR, d);  chk("R1 isr", d, 32'd0);
        rd(A_ACK, d);  chk("R9 ack after reset", d, SPUR);

        wr(A_MASK, 32'd0);
        wr(A_TRIG, 32'h0000_FFFF);

        // R5 sweep of pairs with computed priorities, ties included
        for (int t = 0; t < 16; t++) begin
            int a, b, pa, pb, w, l;
            a = t;
            b = (t * 5 + 3) % 16;
            if (b == a) b = (a + 1) % 16;
            pa = (t * 7) % 15 + 1;
            pb = (t % 4 == 0) ? pa : ((t * 11) % 15 + 1);
            if (pa > pb) w = a;
            else if (pb > pa) w = b;
            else w = (a < b) ? a : b;
            l = (w == a) ? b : a;
            set_prio(a, pa);
            set_prio(b, pb);
            pulse(N'(1 << a) | N'(1 << b));
            tick(3);
            chk("R5 irq raised", {31'd0, irq_o}, 32'd1);
            rd(A_ACK, d); chk("R5 winner", d, 32'(w));
            tick(3);
            chk("R7 loser held off", {31'd0, irq_o}, 32'd0);
            rd(A_ISR, d); chk("R6 isr bit", d, 32'(1 << w));
            rd(A_ACK, d); chk("R9 spurious while blocked", d, SPUR);
            wr(A_EOI, 32'(w));
            tick(3);
            chk("R8 loser after eoi", {31'd0, irq_o}, 32'd1);
            rd(A_ACK, d); chk("R5 loser taken", d, 32'(l));
            wr(A_EOI, 32'(l));
            set_prio(a, 0);
            set_prio(b, 0);
            tick(3);
            rd(A_ISR, d);  chk("R8 isr empty", d, 32'd0);
            rd(A_PEND, d); chk("R6 pend empty", d, 32'd0);
        end

        // R7 preemption, equal blocking, R8 stray EOI, R11 current record
        set_prio(2, 5); set_prio(9, 9); set_prio(6, 5);
        pulse(N'(1 << 2)); tick(3);
        rd(A_ACK, d); chk("R5 take 2", d, 32'd2);
        pulse(N'(1 << 9)); tick(3);
        chk("R7 preempt raises", {31'd0, irq_o}, 32'd1);
        rd(A_ACK, d); chk("R7 take 9", d, 32'd9);
        rd(A_ISR, d); chk("R6 nested isr", d, 32'h0000_0204);
        rd(A_CUR, d); chk("R11 cur after ack", d, 32'h0000_0109);
        wr(A_EOI, 32'd9);
        rd(A_CUR, d); chk("R11 cur valid cleared", d & 32'h100, 32'd0);
        pulse(N'(1 << 6)); tick(3);
        chk("R7 equal blocked", {31'd0, irq_o}, 32'd0);
        wr(A_EOI, 32'd12);
        rd(A_ISR, d); chk("R8 stray eoi", d, 32'h0000_0004);
        wr(A_EOI, 32'd2); tick(3);
        chk("R7 equal after eoi", {31'd0, irq_o}, 32'd1);
        rd(A_ACK, d); chk("R7 take 6", d, 32'd6);
        wr(A_EOI, 32'd6);
        set_prio(2, 0); set_prio(9, 0); set_prio(6, 0);

        // R4 masked and priority-zero lines latch but stay silent
        set_prio(10, 7);
        wr(A_MASK, 32'(1 << 10));
        pulse(N'(1 << 10)); tick(3);
        chk("R4 masked silent", {31'd0, irq_o}, 32'd0);
        rd(A_PEND, d); chk("R4 masked latched", d, 32'(1 << 10));
        rd(A_ACK, d); chk("R4 masked not taken", d, SPUR);
        wr(A_MASK, 32'd0); tick(3);
        chk("R4 unmask raises", {31'd0, irq_o}, 32'd1);
        wr(A_PEND, 32'(1 << 10)); tick(3);
        chk("R3 w1c drops", {31'd0, irq_o}, 32'd0);
        set_prio(10, 0);
        pulse(N'(1 << 11)); tick(3);
        chk("R4 prio zero silent", {31'd0, irq_o}, 32'd0);
        rd(A_PEND, d); chk("R4 prio zero latched", d, 32'(1 << 11));
        wr(A_PEND, 32'(1 << 11));

        // R2 edge line held high posts once
        set_prio(1, 3);
        @(negedge clk); irq_in[1] = 1'b1;
        tick(3);
        rd(A_ACK, d); chk("R2 edge taken", d, 32'd1);
        tick(3);
        rd(A_PEND, d); chk("R2 no repost", d, 32'd0);
        chk("R2 irq low", {31'd0, irq_o}, 32'd0);
        @(negedge clk); irq_in[1] = 1'b0;
        wr(A_EOI, 32'd1);
        set_prio(1, 0);

        // R3 level line re-posts
        wr(A_TRIG, 32'h0000_FFF7);
        set_prio(3, 4);
        @(negedge clk); irq_in[3] = 1'b1;
        tick(3);
        chk("R3 level raises", {31'd0, irq_o}, 32'd1);
        rd(A_ACK, d); chk("R3 level taken", d, 32'd3);
        tick(3);
        rd(A_PEND, d); chk("R3 repost after ack", d, 32'(1 << 3));
        chk("R7 own repost blocked", {31'd0, irq_o}, 32'd0);
        wr(A_EOI, 32'd3); tick(3);
        chk("R3 raises after eoi", {31'd0, irq_o}, 32'd1);
        wr(A_PEND, 32'(1 << 3)); tick(3);
        rd(A_PEND, d); chk("R3 w1c overridden", d, 32'(1 << 3));
        @(negedge clk); irq_in[3] = 1'b0;
        wr(A_PEND, 32'(1 << 3)); tick(3);
        rd(A_PEND, d); chk("R3 cleared when low", d, 32'd0);
        chk("R3 irq low", {31'd0, irq_o}, 32'd0);
        wr(A_TRIG, 32'h0000_FFFF);
        set_prio(3, 0);

        // R10 stale acknowledge after mask write
        set_prio(4, 3); set_prio(8, 8);
        pulse(N'(1 << 4) | N'(1 << 8)); tick(3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_MASK; reg_wdata = 32'(1 << 8);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = A_ACK;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R10 stale winner", d, 32'd8);
        wr(A_EOI, 32'd8); tick(2);
        rd(A_ACK, d); chk("R10 fresh winner", d, 32'd4);
        wr(A_EOI, 32'd4);
        wr(A_MASK, 32'd0);
        set_prio(4, 0); set_prio(8, 0);

        // R10 pending view lags one cycle
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); irq_in[5] = 1'b0; reg_rd = 1'b1; reg_addr = A_PEND;
        #1 d = reg_rdata;
        chk("R10 pend view old", d, 32'd0);
        @(negedge clk);
        #1 d = reg_rdata;
        chk("R10 pend view new", d, 32'(1 << 5));
        @(negedge clk); reg_rd = 1'b0;
        wr(A_PEND, 32'(1 << 5));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule